// File: doc/BRIEF.md
# Two-Bank SDRAM Command Decoder and Bank State Tracker

This block models the command front end of a low-power SDRAM with two banks, as seen from the device side. On every rising clock it samples the clock enable (now and on the previous edge), the four active-low command strobes and the address bus. It decodes the command and moves each bank through its own life cycle: idle, opening, open, reading, writing, precharging. It also tracks the device-wide modes: refresh, mode register access, self refresh with its exit recovery, power down and deep power down.

Every command is checked against the current state and against minimum spacing rules, which are set as cycle-count parameters. A command that breaks a rule raises a one-cycle illegal flag and has no effect. The block is meant to sit beside a memory controller in simulation, or in a checker role on silicon, and report protocol misuse. Data storage, pad drivers and analog timing are outside its scope. The only data-path piece it models is the byte-mask timing. No stream interface exists, so every pin is a plain control or status signal. Every timing parameter must be at least 2.

Top module: `lpsdr_cmd_tracker`

## Requirements
- R1: The strobes {cs_n,ras_n,cas_n,we_n} decode as follows: cs_n high is deselect (code 0), 0111 is no-op (1), 0011 is activate (2), 0101 is read (3), 0100 is write (4), 0010 is precharge (5), 0001 is refresh (6), 0000 is mode set (7) and 0110 is burst stop (8). `cmd_q` shows the code one cycle after the edge.
- R2: An activate to an idle bank takes the bank to state 1 (opening). After T_RCD-1 cycles the bank is in state 2 (open). A read or write issued before T_RCD edges have passed, or issued to an idle bank, is illegal. An activate to a bank that is not idle is illegal. An activate to any bank fewer than T_RRD edges after the last activate is illegal.
- R3: A read or write to an open bank puts it in state 3 or state 4 for the burst length, then back in state 2. With address bit 10 set, the bank instead goes to state 5 (precharging). The burst length comes from mode bits [2:0]: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8, 7 gives 256, and any other value gives 1. Mode bit 9 set makes every write one cycle long.
- R4: A precharge acts on all banks when address bit 10 is high, and otherwise on the bank selected by bit 11. It is illegal fewer than T_RAS edges after that bank's activate. A bank stays in state 5 for T_RP-1 cycles and then reaches state 0 (idle). A precharge to an idle bank is legal and has no effect.
- R5: A read, write or precharge to a bank bursting without auto-precharge cuts that burst short and starts the new operation. Burst stop returns such bursts to state 2. Any read, write or precharge aimed at a bank bursting with auto-precharge is illegal, and so is a burst stop while any such burst runs.
- R6: Refresh with CKE held high and all banks idle sets the global state to 1. The global state returns to 0 so that a new command is accepted T_RC edges later, and any command other than no-op or deselect in between is illegal. Refresh with any bank not idle is illegal.
- R7: A mode set with all banks idle stores address bits [10:0] in the base register when bit 11 is 0, and in the extended register when bit 11 is 1. It sets the global state to 2 for one cycle. A mode set with any bank busy is illegal.
- R8: Refresh sampled with CKE falling from high and all banks idle enters self refresh (global state 3). Commands are ignored while CKE stays low. CKE high exits to state 4, where any command other than no-op or deselect is illegal. Commands are accepted again T_XSR edges after the exit edge.
- R9: Burst stop sampled with CKE falling and all banks idle enters deep power down (state 6). The block leaves only when CKE is sampled high. No-op or deselect sampled with CKE falling and all banks idle enters power down (state 5), which also ends on CKE high. Burst stop or refresh sampled with CKE falling while a bank is busy is illegal.
- R10: `illegal` pulses for exactly the cycle after a rejected command, and the rejected command changes no bank, register or global state.
- R11: `wr_mask` follows `dqm` in the same cycle. `rd_mask` carries the `dqm` value sampled one edge earlier, so that it applies to read data at the second edge after sampling.
- R12: Reset sets all banks to idle, the global state to 0, both mode registers to 0, and `illegal` and `cmd_q` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable sample |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Bank select in the top bit, auto-precharge / all-banks in bit 10, op code in bits [10:0] |
| dqm | input | DQM_W | Byte mask |
| cmd_q | output | 4 | Registered command code |
| illegal | output | 1 | Rejected-command pulse |
| bank_state | output | 3*NB | State code of each bank, bank 0 in the low bits |
| glob_state | output | 3 | Device-wide state code |
| mode_reg | output | ADDR_W-1 | Base mode register |
| ext_reg | output | ADDR_W-1 | Extended mode register |
| rd_mask | output | DQM_W | Mask for read data |
| wr_mask | output | DQM_W | Mask for write data |

## Verification
The bench targets the off-by-one edges of each timer. It issues a read one edge early after an activate, a second activate inside the row-to-row window, and a precharge inside the activate-to-precharge window. A tracker whose counters were one cycle slow would accept these commands, or would reject the first legal edge after them. It also aims commands at a bank that is bursting with auto-precharge, where a design that lets them through would corrupt the closing row. It checks that burst stop and refresh with CKE falling split correctly between deep power down, self refresh and rejection, depending on bank activity. Randomized burst lengths, directions and auto-precharge choices confirm the burst and precharge durations against lengths the bench computes itself.

// File: rtl/lpsdr_pkg.sv
package lpsdr_pkg;
  localparam int BURST_W = 9;

  typedef enum logic [3:0] {
    CMD_DESEL = 4'd0, CMD_NOP = 4'd1, CMD_ACT = 4'd2, CMD_RD = 4'd3, CMD_WR = 4'd4,
    CMD_PRE = 4'd5, CMD_REF = 4'd6, CMD_MRS = 4'd7, CMD_BST = 4'd8
  } cmd_e;

  typedef enum logic [2:0] {
    BK_IDLE = 3'd0, BK_OPEN = 3'd1, BK_ACTIVE = 3'd2, BK_RD = 3'd3, BK_WR = 3'd4, BK_PRE = 3'd5
  } bank_e;

  typedef enum logic [2:0] {
    GS_RUN = 3'd0, GS_REF = 3'd1, GS_MRS = 3'd2, GS_SELF = 3'd3, GS_SRX = 3'd4,
    GS_PDN = 3'd5, GS_DPD = 3'd6
  } glob_e;

  function automatic logic [BURST_W-1:0] blen_of(input logic [2:0] code);
    case (code)
      3'd1:    return BURST_W'(2);
      3'd2:    return BURST_W'(4);
      3'd3:    return BURST_W'(8);
      3'd7:    return BURST_W'(256);
      default: return BURST_W'(1);
    endcase
  endfunction
endpackage

// File: rtl/lpsdr_cmd_decode.sv
module lpsdr_cmd_decode
  import lpsdr_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  always_comb begin
    if (cs_n) cmd = CMD_DESEL;
    else begin
      case ({ras_n, cas_n, we_n})
        3'b111:  cmd = CMD_NOP;
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b010:  cmd = CMD_PRE;
        3'b001:  cmd = CMD_REF;
        3'b000:  cmd = CMD_MRS;
        default: cmd = CMD_BST;
      endcase
    end
  end
endmodule

// File: rtl/lpsdr_bank_fsm.sv
module lpsdr_bank_fsm
  import lpsdr_pkg::*;
#(
  parameter int T_RCD = 3,
  parameter int T_RP  = 3,
  parameter int T_RAS = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               act,
  input  logic               rw,
  input  logic               rw_wr,
  input  logic               rw_ap,
  input  logic               pre,
  input  logic               stop,
  input  logic [BURST_W-1:0] blen,
  output bank_e              st,
  output logic               ap_burst,
  output logic               ras_ok
);
  localparam int RAS_W = $clog2(T_RAS + 1);

  logic [BURST_W-1:0] cnt;
  logic [RAS_W-1:0]   ras_cnt;
  logic               ap_q;

  assign ap_burst = ap_q && (st == BK_RD || st == BK_WR);
  assign ras_ok   = (ras_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= BK_IDLE; cnt <= '0; ap_q <= 1'b0; ras_cnt <= '0;
    end else begin
      if (act) ras_cnt <= RAS_W'(T_RAS - 1);
      else if (ras_cnt != '0) ras_cnt <= ras_cnt - 1'b1;

      if (act) begin
        st <= BK_OPEN; cnt <= BURST_W'(T_RCD - 1);
      end else if (rw) begin
        st <= rw_wr ? BK_WR : BK_RD; cnt <= blen; ap_q <= rw_ap;
      end else if (pre) begin
        st <= BK_PRE; cnt <= BURST_W'(T_RP - 1); ap_q <= 1'b0;
      end else if (stop) begin
        st <= BK_ACTIVE; ap_q <= 1'b0;
      end else begin
        case (st)
          BK_OPEN: if (cnt <= 1) st <= BK_ACTIVE; else cnt <= cnt - 1'b1;
          BK_RD, BK_WR:
            if (cnt <= 1) begin
              if (ap_q) begin st <= BK_PRE; cnt <= BURST_W'(T_RP - 1); ap_q <= 1'b0; end
              else st <= BK_ACTIVE;
            end else cnt <= cnt - 1'b1;
          BK_PRE: if (cnt <= 1) st <= BK_IDLE; else cnt <= cnt - 1'b1;
          default: ;
        endcase
      end
    end
  end

  a_r2_act_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    act |-> st == BK_IDLE);
  a_r4_pre_drains: assert property (@(posedge clk) disable iff (!rst_n)
    (st == BK_PRE && !act && !rw && !pre) |=> (st == BK_PRE || st == BK_IDLE));
  a_r5_ap_locked: assert property (@(posedge clk) disable iff (!rst_n)
    ap_burst |-> !(rw || pre || stop));
endmodule

// File: rtl/lpsdr_cmd_tracker.sv
module lpsdr_cmd_tracker
  import lpsdr_pkg::*;
#(
  parameter int NB     = 2,
  parameter int ADDR_W = 12,
  parameter int DQM_W  = 2,
  parameter int T_RCD  = 3,
  parameter int T_RP   = 3,
  parameter int T_RAS  = 6,
  parameter int T_RRD  = 2,
  parameter int T_RC   = 6,
  parameter int T_XSR  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cke,
  input  logic                cs_n,
  input  logic                ras_n,
  input  logic                cas_n,
  input  logic                we_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DQM_W-1:0]    dqm,
  output logic [3:0]          cmd_q,
  output logic                illegal,
  output logic [3*NB-1:0]     bank_state,
  output logic [2:0]          glob_state,
  output logic [ADDR_W-2:0]   mode_reg,
  output logic [ADDR_W-2:0]   ext_reg,
  output logic [DQM_W-1:0]    rd_mask,
  output logic [DQM_W-1:0]    wr_mask
);
  localparam int BA_W   = $clog2(NB);
  localparam int OP_W   = ADDR_W - 1;
  localparam int AP_BIT = ADDR_W - 2;
  localparam int G_W    = $clog2(T_RC + T_XSR + 1);
  localparam int R_W    = $clog2(T_RRD + 1);

  cmd_e  cmd;
  glob_e gst, gst_n;
  bank_e bst [NB];
  logic [NB-1:0] ap_b, rasok, act_v, rw_v, pre_v, stop_v;
  logic [G_W-1:0] gcnt, gload;
  logic [R_W-1:0] rrd_cnt;
  logic [BURST_W-1:0] blen;
  logic [DQM_W-1:0] dq1;
  logic cke_q, legal, all_idle, any_ap, is_nop, a10, mrs_wr, gdo_load;
  logic [BA_W-1:0] tgt;

  lpsdr_cmd_decode u_dec (.cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd));

  assign tgt    = addr[ADDR_W-1 -: BA_W];
  assign a10    = addr[AP_BIT];
  assign is_nop = (cmd == CMD_NOP) || (cmd == CMD_DESEL);
  assign blen   = (cmd == CMD_WR && mode_reg[9]) ? BURST_W'(1) : blen_of(mode_reg[2:0]);

  for (genvar b = 0; b < NB; b++) begin : g_bank
    lpsdr_bank_fsm #(.T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS)) u_bank (
      .clk(clk), .rst_n(rst_n), .act(act_v[b]), .rw(rw_v[b]), .rw_wr(cmd == CMD_WR),
      .rw_ap(a10), .pre(pre_v[b]), .stop(stop_v[b]), .blen(blen),
      .st(bst[b]), .ap_burst(ap_b[b]), .ras_ok(rasok[b]));
    assign bank_state[3*b +: 3] = bst[b];
  end

  always_comb begin
    all_idle = 1'b1; any_ap = 1'b0;
    for (int b = 0; b < NB; b++) begin
      if (bst[b] != BK_IDLE) all_idle = 1'b0;
      if (ap_b[b]) any_ap = 1'b1;
    end
  end

  always_comb begin
    legal = 1'b1; gst_n = gst; gdo_load = 1'b0; gload = '0; mrs_wr = 1'b0;
    act_v = '0; rw_v = '0; pre_v = '0; stop_v = '0;
    case (gst)
      GS_RUN: if (cke_q) begin
        if (!cke && all_idle && (is_nop || cmd == CMD_REF || cmd == CMD_BST))
          gst_n = is_nop ? GS_PDN : (cmd == CMD_REF) ? GS_SELF : GS_DPD;
        else if (!cke && (cmd == CMD_REF || cmd == CMD_BST))
          legal = 1'b0;
        else begin
          case (cmd)
            CMD_ACT:
              if (bst[tgt] != BK_IDLE || rrd_cnt != '0) legal = 1'b0;
              else act_v[tgt] = 1'b1;
            CMD_RD, CMD_WR:
              if (bst[tgt] == BK_ACTIVE ||
                  ((bst[tgt] == BK_RD || bst[tgt] == BK_WR) && !ap_b[tgt])) rw_v[tgt] = 1'b1;
              else legal = 1'b0;
            CMD_PRE: begin
              for (int b = 0; b < NB; b++) begin
                if (a10 || tgt == BA_W'(b)) begin
                  if (bst[b] == BK_OPEN || ap_b[b]) legal = 1'b0;
                  else if (bst[b] == BK_ACTIVE || bst[b] == BK_RD || bst[b] == BK_WR) begin
                    if (!rasok[b]) legal = 1'b0;
                    else pre_v[b] = 1'b1;
                  end
                end
              end
              if (!legal) pre_v = '0;
            end
            CMD_REF:
              if (!all_idle) legal = 1'b0;
              else begin gst_n = GS_REF; gdo_load = 1'b1; gload = G_W'(T_RC - 2); end
            CMD_MRS:
              if (!all_idle) legal = 1'b0;
              else begin gst_n = GS_MRS; gdo_load = 1'b1; mrs_wr = 1'b1; end
            CMD_BST:
              if (any_ap) legal = 1'b0;
              else for (int b = 0; b < NB; b++)
                stop_v[b] = (bst[b] == BK_RD || bst[b] == BK_WR);
            default: ;
          endcase
        end
      end
      GS_REF, GS_MRS, GS_SRX: begin
        if (!is_nop) legal = 1'b0;
        if (gcnt == '0) gst_n = GS_RUN;
      end
      GS_SELF: if (cke) begin
        if (!is_nop) legal = 1'b0;
        gst_n = GS_SRX; gdo_load = 1'b1; gload = G_W'(T_XSR - 2);
      end
      default: if (cke) gst_n = GS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gst <= GS_RUN; gcnt <= '0; rrd_cnt <= '0; cke_q <= 1'b1; illegal <= 1'b0;
      cmd_q <= '0; mode_reg <= '0; ext_reg <= '0; dq1 <= '0; rd_mask <= '0;
    end else begin
      gst     <= gst_n;
      cke_q   <= cke;
      illegal <= !legal;
      cmd_q   <= cmd;
      dq1     <= dqm;
      rd_mask <= dq1;
      if (gdo_load) gcnt <= gload;
      else if (gcnt != '0) gcnt <= gcnt - 1'b1;
      if (|act_v) rrd_cnt <= R_W'(T_RRD - 1);
      else if (rrd_cnt != '0) rrd_cnt <= rrd_cnt - 1'b1;
      if (mrs_wr && !addr[ADDR_W-1]) mode_reg <= addr[OP_W-1:0];
      if (mrs_wr &&  addr[ADDR_W-1]) ext_reg  <= addr[OP_W-1:0];
    end
  end

  assign glob_state = gst;
  assign wr_mask    = dqm;

  a_r7_mrs_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (gst == GS_MRS && $past(gst) != GS_MRS) |-> $past(all_idle));
  a_r8_self_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (gst == GS_SELF && $past(gst) != GS_SELF) |-> $past(all_idle));
  a_r9_dpd_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (gst == GS_DPD && !cke) |=> gst == GS_DPD);
  a_r10_illegal_source: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> ($past(cmd) != CMD_NOP && $past(cmd) != CMD_DESEL));
  a_r2_one_act: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(act_v) <= 1);
endmodule

// File: tb/test_lpsdr_cmd_tracker.sv
`timescale 1ns/1ps
module test_lpsdr_cmd_tracker;
  localparam int T_RCD = 3, T_RP = 3, T_RAS = 6, T_RRD = 2, T_RC = 6, T_XSR = 3;
  localparam int C_DES = 0, C_NOP = 1, C_ACT = 2, C_RD = 3, C_WR = 4, C_PRE = 5,
                 C_REF = 6, C_MRS = 7, C_BST = 8;

  logic clk = 1'b0, rst_n = 1'b0, cke = 1'b1;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [11:0] addr = '0;
  logic [1:0]  dqm = '0;
  logic [3:0]  cmd_q;
  logic        illegal;
  logic [5:0]  bank_state;
  logic [2:0]  glob_state;
  logic [10:0] mode_reg, ext_reg;
  logic [1:0]  rd_mask, wr_mask;

  lpsdr_cmd_tracker #(.T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS), .T_RRD(T_RRD),
                      .T_RC(T_RC), .T_XSR(T_XSR)) i_lpsdr_cmd_tracker (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .addr(addr), .dqm(dqm), .cmd_q(cmd_q), .illegal(illegal),
    .bank_state(bank_state), .glob_state(glob_state), .mode_reg(mode_reg),
    .ext_reg(ext_reg), .rd_mask(rd_mask), .wr_mask(wr_mask));

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] pins(input int c);
    case (c)
      C_NOP: return 4'b0111;  C_ACT: return 4'b0011;  C_RD:  return 4'b0101;
      C_WR:  return 4'b0100;  C_PRE: return 4'b0010;  C_REF: return 4'b0001;
      C_MRS: return 4'b0000;  C_BST: return 4'b0110;  default: return 4'b1111;
    endcase
  endfunction

  function automatic int exp_blen(input int code);
    case (code) 1: return 2; 2: return 4; 3: return 8; 7: return 256; default: return 1; endcase
  endfunction

  function automatic int bk(input int b);
    return int'(bank_state[3*b +: 3]);
  endfunction

  task automatic step(input bit k, input int c, input int b, input bit ap, input logic [10:0] op);
    @(negedge clk);
    cke = k;
    {cs_n, ras_n, cas_n, we_n} = pins(c);
    addr = {b[0], ap, op[9:0]};
    @(posedge clk);
    #1;
  endtask

  task automatic nop1();
    step(1'b1, C_NOP, 0, 1'b0, 11'd0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int b, ob;
    logic [10:0] op, eop;
    logic [1:0] prevd;
    void'($urandom(32'd5813));
    repeat (3) @(posedge clk);
    #1;
    chk("R12 glob", glob_state, 0);
    chk("R12 banks", bank_state, 0);
    chk("R12 illegal", illegal, 0);
    chk("R12 mode", mode_reg, 0);
    chk("R12 cmd", cmd_q, 0);
    @(negedge clk); rst_n = 1'b1;

    op = {1'b0, 1'b0, 2'b00, 3'b010 + 3'($urandom % 2), 1'b0, 3'b010};
    step(1, C_MRS, 0, op[10], op);
    chk("R7 base reg", mode_reg, op);
    chk("R7 glob mrs", glob_state, 2);
    chk("R1 cmd mrs", cmd_q, 7);
    chk("R10 mrs legal", illegal, 0);
    nop1();
    chk("R7 back to run", glob_state, 0);
    chk("R1 cmd nop", cmd_q, 1);
    eop = 11'($urandom);
    step(1, C_MRS, 1, eop[10], eop);
    chk("R7 ext reg", ext_reg, eop);
    chk("R7 base kept", mode_reg, op);
    nop1();

    b = $urandom % 2; ob = 1 - b;
    step(1, C_ACT, b, 0, 11'h055);
    chk("R2 opening", bk(b), 1);
    chk("R1 cmd act", cmd_q, 2);
    step(1, C_ACT, ob, 0, 11'h0);
    chk("R2 rrd illegal", illegal, 1);
    chk("R10 ob untouched", bk(ob), 0);
    step(1, C_RD, b, 0, 11'h0);
    chk("R2 rcd illegal", illegal, 1);
    chk("R2 open", bk(b), 2);
    step(1, C_RD, b, 0, 11'h0);
    chk("R3 read legal", illegal, 0);
    chk("R3 reading", bk(b), 3);
    chk("R1 cmd rd", cmd_q, 3);
    for (int i = 0; i < 3; i++) begin nop1(); chk("R3 read len4", bk(b), 3); end
    nop1();
    chk("R3 read done", bk(b), 2);

    step(1, C_ACT, ob, 0, 11'h0);
    chk("R2 act ob", bk(ob), 1);
    nop1(); nop1();
    chk("R2 ob open", bk(ob), 2);
    step(1, C_PRE, ob, 0, 11'h0);
    chk("R4 tras illegal", illegal, 1);
    chk("R10 ob still open", bk(ob), 2);
    step(1, C_WR, ob, 1, 11'h0);
    chk("R3 writing ap", bk(ob), 4);
    step(1, C_RD, ob, 0, 11'h0);
    chk("R5 ap burst locked", illegal, 1);
    chk("R5 still writing", bk(ob), 4);
    nop1(); nop1();
    chk("R3 write len4", bk(ob), 4);
    nop1();
    chk("R3 auto precharge", bk(ob), 5);
    nop1();
    chk("R4 precharging", bk(ob), 5);
    nop1();
    chk("R4 idle after trp", bk(ob), 0);

    step(1, C_RD, b, 0, 11'h0);
    step(1, C_WR, b, 0, 11'h0);
    chk("R5 interrupt legal", illegal, 0);
    chk("R5 interrupt to write", bk(b), 4);
    step(1, C_BST, 0, 0, 11'h0);
    chk("R5 burst stop", bk(b), 2);
    chk("R1 cmd bst", cmd_q, 8);
    step(1, C_REF, 0, 0, 11'h0);
    chk("R6 refresh busy illegal", illegal, 1);
    chk("R6 glob stays", glob_state, 0);
    step(1, C_PRE, 0, 1, 11'h0);
    chk("R4 pre all legal", illegal, 0);
    chk("R4 pre all b", bk(b), 5);
    chk("R4 idle bank no effect", bk(ob), 0);
    nop1(); nop1();
    chk("R4 all idle", bank_state, 0);

    step(1, C_REF, 0, 0, 11'h0);
    chk("R6 refreshing", glob_state, 1);
    step(1, C_ACT, b, 0, 11'h0);
    chk("R6 act during refresh", illegal, 1);
    chk("R10 bank unchanged", bk(b), 0);
    for (int i = 0; i < 3; i++) begin nop1(); chk("R6 still refreshing", glob_state, 1); end
    nop1();
    chk("R6 refresh done", glob_state, 0);

    step(0, C_REF, 0, 0, 11'h0);
    chk("R8 self refresh", glob_state, 3);
    step(0, C_ACT, b, 0, 11'h0);
    chk("R8 ignored in self", illegal, 0);
    chk("R8 stays self", glob_state, 3);
    step(1, C_NOP, 0, 0, 11'h0);
    chk("R8 exit recovery", glob_state, 4);
    step(1, C_ACT, b, 0, 11'h0);
    chk("R8 act in recovery", illegal, 1);
    chk("R8 bank idle", bk(b), 0);
    nop1();
    chk("R8 recovered", glob_state, 0);

    step(0, C_BST, 0, 0, 11'h0);
    chk("R9 deep power down", glob_state, 6);
    step(0, C_NOP, 0, 0, 11'h0);
    chk("R9 dpd holds", glob_state, 6);
    step(1, C_NOP, 0, 0, 11'h0);
    chk("R9 dpd exit", glob_state, 0);
    step(0, C_NOP, 0, 0, 11'h0);
    chk("R9 power down", glob_state, 5);
    step(1, C_NOP, 0, 0, 11'h0);
    chk("R9 pd exit", glob_state, 0);

    step(1, C_ACT, b, 0, 11'h0);
    nop1(); nop1();
    step(0, C_BST, 0, 0, 11'h0);
    chk("R9 dpd busy illegal", illegal, 1);
    chk("R9 no dpd busy", glob_state, 0);
    step(1, C_NOP, 0, 0, 11'h0);
    nop1();
    step(1, C_PRE, b, 0, 11'h0);
    chk("R4 pre after tras", illegal, 0);
    nop1(); nop1();
    chk("R4 idle again", bk(b), 0);

    op = {1'b0, 1'b1, 2'b00, 3'b010, 1'b0, 3'b011};
    step(1, C_MRS, 0, 0, op);
    nop1();
    step(1, C_ACT, b, 0, 11'h0);
    nop1(); nop1();
    step(1, C_WR, b, 0, 11'h0);
    chk("R3 single write", bk(b), 4);
    nop1();
    chk("R3 single write done", bk(b), 2);
    step(1, C_RD, b, 0, 11'h0);
    for (int i = 0; i < 7; i++) begin nop1(); chk("R3 read len8", bk(b), 3); end
    nop1();
    chk("R3 read8 done", bk(b), 2);
    step(1, C_PRE, b, 0, 11'h0);
    nop1(); nop1();

    for (int it = 0; it < 10; it++) begin
      int code, L, rb;
      bit w, ap;
      code = $urandom % 4;
      rb = $urandom % 2;
      w = 1'($urandom);
      ap = 1'($urandom);
      L = exp_blen(code);
      op = {3'b000, 1'b0, 3'b010, 1'b0, 3'(code)};
      step(1, C_MRS, 0, 0, op);
      nop1();
      step(1, C_ACT, rb, 0, 11'h0);
      for (int i = 0; i < T_RCD - 1; i++) nop1();
      step(1, w ? C_WR : C_RD, rb, ap, 11'h0);
      chk("R3 rand start", bk(rb), w ? 4 : 3);
      for (int i = 1; i < L; i++) begin nop1(); chk("R3 rand burst", bk(rb), w ? 4 : 3); end
      nop1();
      chk("R3 rand end", bk(rb), ap ? 5 : 2);
      if (ap) begin
        nop1(); nop1();
      end else begin
        nop1();
        step(1, C_PRE, rb, 0, 11'h0);
        chk("R4 rand pre", bk(rb), 5);
        nop1(); nop1();
      end
      chk("R4 rand idle", bk(rb), 0);
    end

    prevd = dqm;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      dqm = 2'($urandom);
      {cs_n, ras_n, cas_n, we_n} = pins(C_NOP);
      @(posedge clk);
      #1;
      chk("R11 write mask", wr_mask, dqm);
      chk("R11 read mask", rd_mask, prevd);
      prevd = dqm;
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule